// File: doc/BRIEF.md
# Device Visible-State Controller

This block tracks which externally visible state a bus device is in: attached without power, Powered, Default, Address or Configured. Each of these can also carry a suspended flag. Its inputs are bus power presence, a bus-reset indication, a bus-activity indication and a one-millisecond tick. Request handling supplies strobes for address assignment and for configure and deconfigure. Power-management logic supplies the current power source and two attributes of the active configuration: whether it supports both power modes, and whether it needs more than 100 mA.

The outputs tell the rest of the device whether it may answer bus transactions at all, which device address to match, and whether it is suspended. Suspension is a flag laid over the base state. When bus activity returns, the device resumes in the same base state with the same address. Any strobe that arrives while the device is suspended is dropped.

Top module: `usb_dev_state_ctrl`

## Requirements
- R1: With `vbus_i` low the state becomes Attached (encoding 0) with address 0 and not suspended, one cycle later. With `vbus_i` high in Attached the state becomes Powered (encoding 1) one cycle later.
- R2: In Powered, `resp_en_o` is 0, and `addr_set_i`, `cfg_set_i` and `cfg_clr_i` have no effect on state or address.
- R3: With `vbus_i` high, `bus_rst_i` in any state other than Attached, suspended or not, gives Default (encoding 2), address 0 and not suspended one cycle later.
- R4: In Default, `addr_set_i` with a non-zero `addr_i` gives Address (encoding 3) with that address one cycle later. A zero `addr_i` is ignored.
- R5: `cfg_set_i` moves Address to Configured (encoding 4), and `cfg_clr_i` moves Configured back to Address. Both take one cycle and keep the address.
- R6: In Powered or above, `suspended_o` rises in the cycle after the IDLE_MS-th `ms_tick_i` (default 3) counted with no `bus_act_i` or `bus_rst_i`. Any activity restarts the count from zero.
- R7: While suspended, `resp_en_o` is 0 and request strobes are ignored. `bus_act_i` clears `suspended_o` one cycle later and leaves state and address unchanged.
- R8: In Configured, a change of `pwr_self_i` while `cfg_dual_pwr_i` is 0 gives Powered with address 0 one cycle later.
- R9: In Configured with `cfg_dual_pwr_i` = 1, a change of `pwr_self_i` from 1 to 0 while `cfg_high_cur_i` = 1 gives Address with the address kept. Any other change leaves the state as it is.
- R10: `resp_en_o` is 1 exactly in Default, Address and Configured when the device is not suspended. In Default the matched address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbus_i | input | 1 | Bus power present |
| bus_rst_i | input | 1 | Bus reset detected |
| bus_act_i | input | 1 | Bus activity seen this cycle |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| addr_set_i | input | 1 | Address assignment strobe |
| addr_i | input | ADDR_W | Address to assign |
| cfg_set_i | input | 1 | Configure strobe |
| cfg_clr_i | input | 1 | Deconfigure strobe |
| pwr_self_i | input | 1 | 1 = self powered, 0 = bus powered |
| cfg_dual_pwr_i | input | 1 | Active configuration supports both power modes |
| cfg_high_cur_i | input | 1 | Active configuration needs more than 100 mA |
| state_o | output | 3 | Base state: 0 Attached, 1 Powered, 2 Default, 3 Address, 4 Configured |
| resp_en_o | output | 1 | Device may answer bus transactions |
| dev_addr_o | output | ADDR_W | Address to match |
| suspended_o | output | 1 | Suspended flag |

## Verification
Every output is registered, and each one reflects the inputs sampled at a rising edge immediately after that edge. The idle-timeout case works the same way: `suspended_o` rises after the edge that samples the last counted tick, so each result is due one cycle after its stimulus. The bench drives its inputs just after a falling edge and samples at the next falling edge, which places exactly one rising edge between stimulus and check. A behavioural reference model advances on the same rising edge and is compared at every falling edge, through a directed sequence and then a random phase.

// File: rtl/usb_dev_state_pkg.sv
package usb_dev_state_pkg;
  typedef enum logic [2:0] {
    DS_ATTACHED   = 3'd0,
    DS_POWERED    = 3'd1,
    DS_DEFAULT    = 3'd2,
    DS_ADDRESS    = 3'd3,
    DS_CONFIGURED = 3'd4
  } dev_state_e;
endpackage

// File: rtl/dev_idle_timer.sv
module dev_idle_timer #(
  parameter int IDLE_MS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(IDLE_MS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_MS);

  logic [CNT_W-1:0] cnt_q;

  // pulses on the tick that completes the window, once per idle period
  assign expire_o = en_i && !clr_i && tick_i && (cnt_q == LIMIT - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q < LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_src_mon.sv
module pwr_src_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_self_i,
  output logic chg_o,
  output logic was_self_o
);
  logic self_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) self_q <= 1'b0;
    else         self_q <= pwr_self_i;
  end

  assign chg_o      = pwr_self_i != self_q;
  assign was_self_o = self_q;
endmodule

// File: rtl/dev_state_fsm.sv
module dev_state_fsm
  import usb_dev_state_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vbus_i,
  input  logic              bus_rst_i,
  input  logic              bus_act_i,
  input  logic              expire_i,
  input  logic              addr_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_set_i,
  input  logic              cfg_clr_i,
  input  logic              pwr_chg_i,
  input  logic              pwr_was_self_i,
  input  logic              cfg_dual_pwr_i,
  input  logic              cfg_high_cur_i,
  output dev_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              susp_o
);
  dev_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              susp_q, susp_d;
  logic              pwr_hit;

  assign pwr_hit = pwr_chg_i && (state_q == DS_CONFIGURED);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    susp_d  = susp_q;
    if (!vbus_i) begin
      state_d = DS_ATTACHED;
      addr_d  = '0;
      susp_d  = 1'b0;
    end else if (state_q == DS_ATTACHED) begin
      state_d = DS_POWERED;
      susp_d  = 1'b0;
    end else if (bus_rst_i) begin
      state_d = DS_DEFAULT;
      addr_d  = '0;
      susp_d  = 1'b0;
    end else if (pwr_hit && !cfg_dual_pwr_i) begin
      state_d = DS_POWERED;
      addr_d  = '0;
      susp_d  = 1'b0;
    end else begin
      if (susp_q && bus_act_i) susp_d = 1'b0;
      else if (expire_i)       susp_d = 1'b1;
      if (pwr_hit) begin
        // self to bus power with a high-current configuration
        if (pwr_was_self_i && cfg_high_cur_i) state_d = DS_ADDRESS;
      end else if (!susp_q && !expire_i) begin
        unique case (state_q)
          DS_DEFAULT: begin
            if (addr_set_i && addr_i != '0) begin
              state_d = DS_ADDRESS;
              addr_d  = addr_i;
            end
          end
          DS_ADDRESS:    if (cfg_set_i) state_d = DS_CONFIGURED;
          DS_CONFIGURED: if (cfg_clr_i) state_d = DS_ADDRESS;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DS_ATTACHED;
      addr_q  <= '0;
      susp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      susp_q  <= susp_d;
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign susp_o  = susp_q;
endmodule

// File: rtl/usb_dev_state_ctrl.sv
module usb_dev_state_ctrl
  import usb_dev_state_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int IDLE_MS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vbus_i,
  input  logic              bus_rst_i,
  input  logic              bus_act_i,
  input  logic              ms_tick_i,
  input  logic              addr_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_set_i,
  input  logic              cfg_clr_i,
  input  logic              pwr_self_i,
  input  logic              cfg_dual_pwr_i,
  input  logic              cfg_high_cur_i,
  output logic [2:0]        state_o,
  output logic              resp_en_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              suspended_o
);
  dev_state_e st;
  logic       susp, expire, pwr_chg, pwr_was_self;

  dev_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (st != DS_ATTACHED),
    .clr_i    (bus_act_i | bus_rst_i),
    .tick_i   (ms_tick_i),
    .expire_o (expire)
  );

  pwr_src_mon u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_self_i (pwr_self_i),
    .chg_o      (pwr_chg),
    .was_self_o (pwr_was_self)
  );

  dev_state_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .vbus_i         (vbus_i),
    .bus_rst_i      (bus_rst_i),
    .bus_act_i      (bus_act_i),
    .expire_i       (expire),
    .addr_set_i     (addr_set_i),
    .addr_i         (addr_i),
    .cfg_set_i      (cfg_set_i),
    .cfg_clr_i      (cfg_clr_i),
    .pwr_chg_i      (pwr_chg),
    .pwr_was_self_i (pwr_was_self),
    .cfg_dual_pwr_i (cfg_dual_pwr_i),
    .cfg_high_cur_i (cfg_high_cur_i),
    .state_o        (st),
    .addr_o         (dev_addr_o),
    .susp_o         (susp)
  );

  assign state_o     = st;
  assign suspended_o = susp;
  assign resp_en_o   = !susp && (st == DS_DEFAULT || st == DS_ADDRESS || st == DS_CONFIGURED);
endmodule

// File: rtl/dev_state_chk.sv
module dev_state_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vbus_i,
  input logic              bus_rst_i,
  input logic              bus_act_i,
  input logic              cfg_set_i,
  input logic [2:0]        state_o,
  input logic              resp_en_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic              suspended_o
);
  p_unpowered_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_i |=> (state_o == 3'd0 && dev_addr_o == '0 && !suspended_o));

  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 3'd1 || suspended_o) |-> !resp_en_o);

  p_bus_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_i && bus_rst_i && state_o != 3'd0)
      |=> (state_o == 3'd2 && dev_addr_o == '0 && !suspended_o));

  p_configure_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_i && !bus_rst_i && bus_act_i && cfg_set_i && state_o == 3'd3 && !suspended_o)
      |=> state_o == 3'd4);

  p_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && bus_act_i) |=> !suspended_o);

  p_susp_keeps_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && vbus_i && !bus_rst_i && state_o != 3'd4) |=> $stable(dev_addr_o));

  p_default_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |-> dev_addr_o == '0);
endmodule

bind usb_dev_state_ctrl dev_state_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vbus_i      (vbus_i),
  .bus_rst_i   (bus_rst_i),
  .bus_act_i   (bus_act_i),
  .cfg_set_i   (cfg_set_i),
  .state_o     (state_o),
  .resp_en_o   (resp_en_o),
  .dev_addr_o  (dev_addr_o),
  .suspended_o (suspended_o)
);

// File: tb/usb_dev_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_dev_state_ctrl_tb_top;
  localparam int AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vbus = 0, bus_rst = 0, act = 0, tick = 0, addr_set = 0, cfg_set = 0, cfg_clr = 0;
  logic pwr_self = 0, dual = 0, high = 0;
  logic [AW-1:0] addr = '0;
  logic [2:0] state;
  logic resp;
  logic [AW-1:0] dev_addr;
  logic susp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_dev_state_ctrl #(.ADDR_W(AW), .IDLE_MS(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vbus_i(vbus), .bus_rst_i(bus_rst), .bus_act_i(act),
    .ms_tick_i(tick), .addr_set_i(addr_set), .addr_i(addr), .cfg_set_i(cfg_set),
    .cfg_clr_i(cfg_clr), .pwr_self_i(pwr_self), .cfg_dual_pwr_i(dual),
    .cfg_high_cur_i(high), .state_o(state), .resp_en_o(resp), .dev_addr_o(dev_addr),
    .suspended_o(susp)
  );

  // behavioural reference model
  int m_state = 0, m_addr = 0, m_idle = 0;
  bit m_susp = 0, m_pwr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_addr = 0; m_idle = 0; m_susp = 0; m_pwr = 0;
    end else begin
      bit changed, from_self, timeout, old_susp, in_cfg;
      changed = (pwr_self != m_pwr);
      from_self = m_pwr;
      m_pwr = pwr_self;
      timeout = 0;
      if (m_state == 0 || act || bus_rst) m_idle = 0;
      else if (tick && m_idle < 3) begin
        m_idle++;
        timeout = (m_idle == 3);
      end
      old_susp = m_susp;
      in_cfg = changed && m_state == 4;
      if (!vbus) begin
        m_state = 0; m_addr = 0; m_susp = 0;
      end else if (m_state == 0) begin
        m_state = 1; m_susp = 0;
      end else if (bus_rst) begin
        m_state = 2; m_addr = 0; m_susp = 0;
      end else if (in_cfg && !dual) begin
        m_state = 1; m_addr = 0; m_susp = 0;
      end else begin
        if (old_susp && act) m_susp = 0;
        else if (timeout) m_susp = 1;
        if (in_cfg) begin
          if (from_self && high) m_state = 3;
        end else if (!old_susp && !timeout) begin
          if (m_state == 2 && addr_set && addr != 0) begin
            m_state = 3; m_addr = int'(addr);
          end else if (m_state == 3 && cfg_set) m_state = 4;
          else if (m_state == 4 && cfg_clr) m_state = 3;
        end
      end
    end
  end

  task automatic chk(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 model state", int'(state), m_state);
      chk("R4 model address", int'(dev_addr), m_addr);
      chk("R6 model suspended", int'(susp), int'(m_susp));
      chk("R10 model resp_en", int'(resp),
          int'(!m_susp && m_state >= 2));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    bus_rst = 0; act = 0; tick = 0; addr_set = 0; cfg_set = 0; cfg_clr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(); tick = 0; cyc();
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state), 0);
    chk("R1 reset address", int'(dev_addr), 0);
    rst_n = 1;
    cyc(); chk("R1 no vbus", int'(state), 0);
    vbus = 1; pwr_self = 1;
    cyc(); chk("R1 powered", int'(state), 1);
    chk("R2 powered silent", int'(resp), 0);
    addr_set = 1; addr = 7'd9; cfg_set = 1;
    cyc(); clr_strobes();
    chk("R2 strobes ignored state", int'(state), 1);
    chk("R2 strobes ignored addr", int'(dev_addr), 0);
    bus_rst = 1; cyc(); clr_strobes();
    chk("R3 default", int'(state), 2);
    chk("R10 default answers", int'(resp), 1);
    addr_set = 1; addr = 7'd0; cyc(); clr_strobes();
    chk("R4 zero address ignored", int'(state), 2);
    addr_set = 1; addr = 7'd42; cyc(); clr_strobes();
    chk("R4 address state", int'(state), 3);
    chk("R4 address value", int'(dev_addr), 42);
    cfg_set = 1; cyc(); clr_strobes();
    chk("R5 configured", int'(state), 4);
    ticks(2); act = 1; cyc(); clr_strobes(); ticks(2);
    chk("R6 activity restarts count", int'(susp), 0);
    ticks(1);
    chk("R6 suspended after window", int'(susp), 1);
    chk("R7 silent when suspended", int'(resp), 0);
    cfg_clr = 1; cyc(); clr_strobes();
    chk("R7 strobe ignored suspended", int'(state), 4);
    act = 1; cyc(); clr_strobes();
    chk("R7 wake", int'(susp), 0);
    chk("R7 wake state", int'(state), 4);
    chk("R7 wake address", int'(dev_addr), 42);
    cfg_clr = 1; cyc(); clr_strobes();
    chk("R5 deconfigure", int'(state), 3);
    chk("R5 address kept", int'(dev_addr), 42);
    cfg_set = 1; cyc(); clr_strobes();
    dual = 1; high = 1; pwr_self = 0; cyc();
    chk("R9 drop to address", int'(state), 3);
    chk("R9 address kept", int'(dev_addr), 42);
    cfg_set = 1; cyc(); clr_strobes();
    pwr_self = 1; cyc();
    chk("R9 bus to self no change", int'(state), 4);
    high = 0; pwr_self = 0; cyc();
    chk("R9 low current no change", int'(state), 4);
    dual = 0; pwr_self = 1; cyc();
    chk("R8 single mode to powered", int'(state), 1);
    chk("R8 address cleared", int'(dev_addr), 0);
    bus_rst = 1; cyc(); clr_strobes();
    addr_set = 1; addr = 7'd5; cyc(); clr_strobes();
    ticks(3);
    chk("R6 suspend in address", int'(susp), 1);
    bus_rst = 1; cyc(); clr_strobes();
    chk("R3 reset from suspended", int'(state), 2);
    chk("R3 reset clears suspend", int'(susp), 0);
    chk("R3 reset clears address", int'(dev_addr), 0);
    ticks(3);
    act = 1; cyc(); clr_strobes();
    chk("R7 wake to default", int'(state), 2);
    vbus = 0; cyc();
    chk("R1 vbus removed", int'(state), 0);
    vbus = 1;
    for (int i = 0; i < 3000; i++) begin
      vbus     = ($urandom % 64) != 0;
      bus_rst  = ($urandom % 40) == 0;
      act      = ($urandom % 5) == 0;
      tick     = ($urandom % 2) == 0;
      addr_set = ($urandom % 6) == 0;
      addr     = AW'($urandom % 4);
      cfg_set  = ($urandom % 4) == 0;
      cfg_clr  = ($urandom % 7) == 0;
      if (($urandom % 10) == 0) pwr_self = ~pwr_self;
      dual     = ($urandom % 3) != 0;
      high     = ($urandom % 2) == 0;
      cyc();
    end
    clr_strobes();
    cyc();
    finish_run();
  end
endmodule